// File: doc/BRIEF.md
# Interleaved Running Median Filter

This block computes a running median over a sliding window of fixed-width samples for several independent sample streams that share one processing array. Samples arrive on a single bus with a valid strobe. Each accepted sample goes to the next stream in strict rotation, so stream membership is never carried on the bus. Each stream keeps its own window of the most recent samples, and a sample for one stream never disturbs the window of another.

The median is not found by sorting. A pipeline of single-bit stages resolves the result one bit at a time, starting at the most significant bit. In each stage the result bit is the majority value of that bit over the window. Any sample that disagrees with that majority is clamped: its remaining lower bits are all set to the value of the disagreeing bit. This keeps its order relative to the median, so the remaining stages still see a valid window. Logic and storage grow linearly with the window length. A result leaves the array a fixed number of cycles after its sample is accepted and carries the index of its stream. With the default three streams, a stream that receives every third accepted sample gets one result every third cycle.

Top module: `median_interleave`

## Requirements
- R1: While reset is asserted and after it is released, `medianValid` is 0 until a stream has filled its window. The first sample accepted after reset belongs to stream 0. Reset also empties every stream's fill history.
- R2: Each result `medianOut` equals the element at index WIN/2 (zero-based) of the stream's last WIN samples sorted in ascending order, with the current sample included.
- R3: A result appears on the outputs exactly WIDTH clock cycles after the edge that accepts its sample. With the defaults this is 8 cycles.
- R4: Accepted samples are assigned to streams 0, 1, …, STREAMS-1 and then back to 0. The stream index advances only on a cycle with `sampleValid` = 1.
- R5: A stream produces no result for its first WIN-1 accepted samples after reset. From its WIN-th sample on, every accepted sample of that stream produces a result.
- R6: A sample of one stream changes neither the window contents nor the results of any other stream.
- R7: A cycle with `sampleValid` = 0 produces no result WIDTH cycles later and changes no window.
- R8: `medianStream` carries the index of the stream whose sample produced the result. Its value is always below STREAMS.
- R9: Results are exact for extreme and repeated values: windows made only of 0, only of 2^WIDTH-1, or of both alternating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | WIDTH | Sample value, unsigned |
| sampleValid | input | 1 | Sample strobe; each high cycle accepts one sample for the current stream |
| medianOut | output | WIDTH | Median of the window of the tagged stream |
| medianValid | output | 1 | High for one cycle for each result |
| medianStream | output | SLOT_W | Stream index of the current result |

## Verification
The bench drives the array with several input patterns:
- A slow ramp, whose median trails the newest sample by half a window.
- Pseudo-random values with idle gaps, which exercise the majority votes and separate latency errors from rotation errors.
- Constant but different values per stream next to a random stream, which exposes any leak between windows.
- Runs of all-zero, all-ones and alternating extremes, which stress the clamping of eliminated samples.

A second reset in the middle of the run shows that window filling starts over. Every expected median comes from a sort of the bench's own copy of each window.

// File: rtl/medfilt_pkg.sv
package medfilt_pkg;

  // Width of the stream index carried inside the control strobe bundle.
  // The datapath uses only the low bits it needs.
  localparam int unsigned TAG_BITS = 8;

  typedef struct packed {
    logic                shiftEn;  // accept the bus sample into the current stream
    logic                full;     // the current stream's window is full once this sample lands
    logic [TAG_BITS-1:0] slot;     // current stream index
  } ctrlStrobe_t;

endpackage

// File: rtl/mf_control.sv
module mf_control
  import medfilt_pkg::*;
#(
  parameter int unsigned STREAMS = 3,
  parameter int unsigned WIN     = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  output ctrlStrobe_t ctrl
);

  localparam int unsigned SLOT_W = (STREAMS > 1) ? $clog2(STREAMS) : 1;
  localparam int unsigned FILL_W = $clog2(WIN + 1);

  logic [SLOT_W-1:0] slot;
  logic [FILL_W-1:0] fillCount [STREAMS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot <= '0;
      for (int s = 0; s < STREAMS; s++) fillCount[s] <= '0;
    end else if (sampleValid) begin
      slot <= (slot == SLOT_W'(STREAMS - 1)) ? '0 : slot + 1'b1;
      if (fillCount[slot] != FILL_W'(WIN)) fillCount[slot] <= fillCount[slot] + 1'b1;
    end
  end

  always_comb begin
    ctrl         = '0;
    ctrl.shiftEn = sampleValid;
    ctrl.full    = (fillCount[slot] >= FILL_W'(WIN - 1));
    ctrl.slot    = TAG_BITS'(slot);
  end

  // R4: the rotation never leaves the legal stream range
  p_slot_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    int'(slot) < STREAMS);

  // R4, R7: an idle cycle does not move the rotation
  p_slot_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(slot));

  for (genvar g = 0; g < STREAMS; g++) begin : g_fillChk
    // R5: the fill history saturates at one full window
    p_fill_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
      int'(fillCount[g]) <= WIN);
    // R6: only the stream's own samples move its fill history
    p_fill_own_r6: assert property (@(posedge clk) disable iff (!rstN)
      !(sampleValid && int'(slot) == g) |=> $stable(fillCount[g]));
  end

endmodule

// File: rtl/mf_bitstage.sv
module mf_bitstage #(
  parameter int unsigned WIN    = 25,
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned BITIDX = 7,
  parameter int unsigned TAG_W  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [WIN-1:0][WIDTH-1:0]  samIn,
  input  logic [WIDTH-1:0]           medIn,
  input  logic                       vIn,
  input  logic [TAG_W-1:0]           tagIn,
  output logic [WIN-1:0][WIDTH-1:0]  samOut,
  output logic [WIDTH-1:0]           medOut,
  output logic                       vOut,
  output logic [TAG_W-1:0]           tagOut
);

  localparam int unsigned CNT_W = $clog2(WIN + 1);
  localparam logic [WIDTH-1:0] KEEP = {WIDTH{1'b1}} << BITIDX;

  logic [CNT_W-1:0]          onesCount;
  logic                      medBit;
  logic [WIN-1:0][WIDTH-1:0] nextSam;
  logic [WIDTH-1:0]          nextMed;

  // Majority vote over this bit plane, then clamp every loser below this bit.
  always_comb begin
    onesCount = '0;
    for (int k = 0; k < WIN; k++) onesCount = onesCount + CNT_W'(samIn[k][BITIDX]);
    medBit          = (onesCount > CNT_W'(WIN / 2));
    nextMed         = medIn;
    nextMed[BITIDX] = medBit;
    for (int k = 0; k < WIN; k++) begin
      nextSam[k] = samIn[k];
      if (samIn[k][BITIDX] != medBit) begin
        for (int j = 0; j < WIDTH; j++) begin
          if (j < BITIDX) nextSam[k][j] = samIn[k][BITIDX];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      samOut <= '0;
      medOut <= '0;
      vOut   <= 1'b0;
      tagOut <= '0;
    end else begin
      samOut <= nextSam;
      medOut <= nextMed;
      vOut   <= vIn;
      tagOut <= tagIn;
    end
  end

  // Rank bookkeeping on the resolved upper bits, used only by the checks below.
  logic [CNT_W-1:0] belowCnt, aboveCnt;
  always_comb begin
    belowCnt = '0;
    aboveCnt = '0;
    for (int k = 0; k < WIN; k++) begin
      if ((samOut[k] & KEEP) < (medOut & KEEP)) belowCnt = belowCnt + CNT_W'(1);
      if ((samOut[k] & KEEP) > (medOut & KEEP)) aboveCnt = aboveCnt + CNT_W'(1);
    end
  end

  // R2: no more than half the window may lie strictly below the resolved prefix
  p_rank_below_r2: assert property (@(posedge clk) disable iff (!rstN)
    vOut |-> int'(belowCnt) <= WIN / 2);

  // R2: no more than half the window may lie strictly above the resolved prefix
  p_rank_above_r2: assert property (@(posedge clk) disable iff (!rstN)
    vOut |-> int'(aboveCnt) <= WIN / 2);

endmodule

// File: rtl/mf_datapath.sv
module mf_datapath
  import medfilt_pkg::*;
#(
  parameter int unsigned STREAMS = 3,
  parameter int unsigned WIN     = 25,
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned SLOT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctrl,
  input  logic [WIDTH-1:0]  sampleIn,
  output logic [WIDTH-1:0]  medianOut,
  output logic              medianValid,
  output logic [SLOT_W-1:0] medianStream
);

  logic [WIN-1:0][WIDTH-1:0] winMem [STREAMS];
  logic [WIN-1:0][WIDTH-1:0] nextWin;
  logic [SLOT_W-1:0]         slotIdx;

  assign slotIdx = ctrl.slot[SLOT_W-1:0];

  // Newest sample enters at entry 0; the oldest entry of this stream falls off.
  always_comb nextWin = {winMem[slotIdx][WIN-2:0], sampleIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STREAMS; s++) winMem[s] <= '0;
    end else if (ctrl.shiftEn) begin
      winMem[slotIdx] <= nextWin;
    end
  end

  // One pipeline stage per bit plane, most significant plane first.
  logic [WIN-1:0][WIDTH-1:0] stageSam [WIDTH+1];
  logic [WIDTH-1:0]          stageMed [WIDTH+1];
  logic                      stageVal [WIDTH+1];
  logic [SLOT_W-1:0]         stageTag [WIDTH+1];

  assign stageSam[0] = nextWin;
  assign stageMed[0] = '0;
  assign stageVal[0] = ctrl.shiftEn & ctrl.full;
  assign stageTag[0] = slotIdx;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    mf_bitstage #(
      .WIN   (WIN),
      .WIDTH (WIDTH),
      .BITIDX(WIDTH - 1 - i),
      .TAG_W (SLOT_W)
    ) uStage (
      .clk   (clk),
      .rstN  (rstN),
      .samIn (stageSam[i]),
      .medIn (stageMed[i]),
      .vIn   (stageVal[i]),
      .tagIn (stageTag[i]),
      .samOut(stageSam[i+1]),
      .medOut(stageMed[i+1]),
      .vOut  (stageVal[i+1]),
      .tagOut(stageTag[i+1])
    );
  end

  assign medianOut    = stageMed[WIDTH];
  assign medianValid  = stageVal[WIDTH];
  assign medianStream = stageTag[WIDTH];

  for (genvar g = 0; g < STREAMS; g++) begin : g_winChk
    // R6, R7: a window changes only on an accepted sample of its own stream
    p_window_isolated_r6: assert property (@(posedge clk) disable iff (!rstN)
      !(ctrl.shiftEn && int'(slotIdx) == g) |=> $stable(winMem[g]));
  end

  // R8: a result always carries a legal stream index
  p_tag_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    medianValid |-> int'(medianStream) < STREAMS);

endmodule

// File: rtl/median_interleave.sv
module median_interleave
  import medfilt_pkg::*;
#(
  parameter int unsigned STREAMS = 3,
  parameter int unsigned WIN     = 25,
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned SLOT_W  = (STREAMS > 1) ? $clog2(STREAMS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  sampleIn,
  input  logic              sampleValid,
  output logic [WIDTH-1:0]  medianOut,
  output logic              medianValid,
  output logic [SLOT_W-1:0] medianStream
);

  ctrlStrobe_t ctrl;

  mf_control #(
    .STREAMS(STREAMS),
    .WIN    (WIN)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .ctrl       (ctrl)
  );

  mf_datapath #(
    .STREAMS(STREAMS),
    .WIN    (WIN),
    .WIDTH  (WIDTH),
    .SLOT_W (SLOT_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .sampleIn    (sampleIn),
    .medianOut   (medianOut),
    .medianValid (medianValid),
    .medianStream(medianStream)
  );

  // R1: no result can leave the array while reset is held
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rstN |-> !medianValid);

endmodule

// File: tb/median_interleave_test.sv
module median_interleave_test;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;
  localparam int NW = 25;
  localparam int NB = 8;
  localparam int DEPTH = 8192;

  logic          clk;
  logic          rstN;
  logic [NB-1:0] sampleIn;
  logic          sampleValid;
  logic [NB-1:0] medianOut;
  logic          medianValid;
  logic [1:0]    medianStream;

  median_interleave #(.STREAMS(NS), .WIN(NW), .WIDTH(NB)) uut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .medianOut(medianOut), .medianValid(medianValid), .medianStream(medianStream)
  );

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit     expV [DEPTH];
  int     expM [DEPTH];
  int     expS [DEPTH];
  string  expTag [DEPTH];
  int     hist [NS][NW];
  int     got [NS];
  int     modelSlot;
  string  phaseTag;
  int unsigned seed = 32'h1234_5678;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hff);
  endfunction

  function automatic int refMedian(int s);
    int tmp [NW];
    for (int i = 0; i < NW; i++) tmp[i] = hist[s][i];
    for (int i = 1; i < NW; i++) begin
      int key = tmp[i];
      int j = i - 1;
      while (j >= 0 && tmp[j] > key) begin
        tmp[j+1] = tmp[j];
        j--;
      end
      tmp[j+1] = key;
    end
    return tmp[NW / 2];
  endfunction

  task automatic modelReset();
    for (int s = 0; s < NS; s++) begin
      got[s] = 0;
      for (int i = 0; i < NW; i++) hist[s][i] = 0;
    end
    modelSlot = 0;
  endtask

  task automatic checkNow();
    int idx = cyc % DEPTH;
    checks++;
    if (medianValid !== expV[idx]) begin
      fails++;
      $display("FAIL %s (R3 R5 R7) valid at cycle %0d got %0b exp %0b",
               expV[idx] ? expTag[idx] : phaseTag, cyc, medianValid, expV[idx]);
    end
    if (expV[idx]) begin
      checks++;
      if (int'(medianOut) !== expM[idx]) begin
        fails++;
        $display("FAIL %s (R2) median at cycle %0d got %0d exp %0d",
                 expTag[idx], cyc, medianOut, expM[idx]);
      end
      checks++;
      if (int'(medianStream) !== expS[idx]) begin
        fails++;
        $display("FAIL R4 R8 stream at cycle %0d got %0d exp %0d",
                 cyc, medianStream, expS[idx]);
      end
    end
    expV[idx] = 1'b0;
  endtask

  // Called at a falling edge; drives one cycle and checks the next falling edge.
  task automatic tick(input bit v, input int d);
    sampleValid = v;
    sampleIn    = NB'(d);
    if (v) begin
      for (int i = NW - 1; i > 0; i--) hist[modelSlot][i] = hist[modelSlot][i-1];
      hist[modelSlot][0] = d;
      if (got[modelSlot] < NW) got[modelSlot]++;
      if (got[modelSlot] >= NW) begin
        int at = (cyc + NB) % DEPTH;
        expV[at]   = 1'b1;
        expM[at]   = refMedian(modelSlot);
        expS[at]   = modelSlot;
        expTag[at] = phaseTag;
      end
      modelSlot = (modelSlot + 1) % NS;
    end
    @(negedge clk);
    checkNow();
  endtask

  task automatic doReset();
    rstN        = 1'b0;
    sampleValid = 1'b0;
    sampleIn    = '0;
    for (int i = 0; i < NB + 6; i++) expV[(cyc + i) % DEPTH] = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (medianValid !== 1'b0) begin
        fails++;
        $display("FAIL R1 valid during reset got %0b exp 0", medianValid);
      end
    end
    rstN = 1'b1;
    modelReset();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) expV[i] = 1'b0;
    rstN = 1'b0;
    sampleValid = 1'b0;
    sampleIn = '0;
    phaseTag = "R1";
    modelReset();
    @(negedge clk);
    doReset();

    // R1 R5: filling phase, the first NW-1 samples of each stream give nothing
    phaseTag = "R5";
    for (int n = 0; n < NS * (NW - 1); n++) tick(1'b1, (n * 3) & 255);

    // R2: slow ramp
    phaseTag = "R2";
    for (int n = 0; n < NS * 40; n++) tick(1'b1, (n * 5 + 17) & 255);

    // R7: random values with idle gaps
    phaseTag = "R7";
    for (int n = 0; n < NS * 60; n++) begin
      int r = nextRand();
      tick(1'b1, nextRand());
      if (r[0]) tick(1'b0, nextRand());
      if (r[1] && r[2]) tick(1'b0, 255);
    end

    // R6: constant but different per stream, random on the third stream
    phaseTag = "R6";
    for (int n = 0; n < NS * 40; n++) begin
      int d;
      case (modelSlot)
        0: d = 10;
        1: d = 200;
        default: d = nextRand();
      endcase
      tick(1'b1, d);
    end

    // R9: alternating extremes, then all ones, then all zeros
    phaseTag = "R9";
    for (int n = 0; n < NS * 30; n++) tick(1'b1, ((n / NS) % 2 == 1) ? 255 : 0);
    for (int n = 0; n < NS * 30; n++) tick(1'b1, 255);
    for (int n = 0; n < NS * 30; n++) tick(1'b1, 0);
    for (int n = 0; n < NS * 20; n++) tick(1'b1, (nextRand() > 127) ? 255 : 0);

    // R1: reset in the middle, windows must fill again from stream 0
    phaseTag = "R1";
    doReset();
    for (int n = 0; n < NS * 35; n++) tick(1'b1, nextRand());

    // drain the pipeline
    phaseTag = "R7";
    for (int n = 0; n < NB + 4; n++) tick(1'b0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d got running exp finished", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule